// File: doc/BRIEF.md
# Descriptor Memory Loader

This block sits behind a byte-wide register command port and watches for completed writes aimed at a single descriptor-access register. The first two bytes written to that register give a 16-bit descriptor length, low byte first. Every later byte is payload. Each payload byte goes out on a RAM write port, starting at address zero and moving up by one per byte. When the number of payload bytes reaches the declared length, the load ends.

When a load ends, the block raises a one-cycle completion pulse and goes back to waiting for a new length. The descriptor memory holds 500 bytes. A declared length larger than that sets a sticky error flag. The loader still counts all declared bytes, but any byte whose index is 500 or more is not written. Writes to any other register address are ignored.

Top module: `desc_loader`

## Requirements
- R1: After a synchronous active-low reset, `ram_we`, `load_done`, `loading` and `len_err` are all 0, and the next accepted byte is taken as the length low byte.
- R2: A byte is accepted only when `byte_vld` is 1 and `byte_reg` equals the access address (default 6'h30). Any other byte causes no RAM write and no state change.
- R3: The first accepted byte is the low byte of the length and the second is the high byte. `loading` is 1 from the clock edge that takes the high byte until the load ends.
- R4: The n-th payload byte (counting from 0) is written at address n with its own data value. `ram_we` is high for exactly one cycle, in the cycle after the edge that accepts the byte.
- R5: `load_done` pulses high for one cycle in the same cycle as the write of the final payload byte. After that, the next accepted byte is taken as a new length low byte.
- R6: A declared length of zero raises `load_done` in the cycle after the high byte, with no RAM write, and `loading` stays 0.
- R7: A declared length above 500 sets `len_err` in the cycle after the high byte. The flag stays set until reset. Payload bytes with index 500 or more produce no write, but they still count toward completion. A length of exactly 500 does not set the flag.
- R8: A reset in the middle of a load clears the length, the pointer, `loading` and `len_err`.
- R9: Idle cycles (`byte_vld` low) between accepted bytes have no effect on the load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| byte_vld | input | 1 | A completed register byte is present this cycle |
| byte_reg | input | 6 | Register address the byte targets |
| byte_data | input | 8 | Byte value |
| ram_we | output | 1 | Descriptor RAM write strobe |
| ram_addr | output | 9 | Descriptor RAM write address |
| ram_wdata | output | 8 | Descriptor RAM write data |
| load_done | output | 1 | One-cycle pulse when the declared length has been loaded |
| loading | output | 1 | Payload phase in progress |
| len_err | output | 1 | Sticky flag for a declared length above the memory size |

## Verification
A wrong phase state shows up at the ports one cycle after the next accepted byte. A payload byte is then taken as length, so `ram_we` is missing, or a length byte is written into the RAM. A pointer that is off by one shows on `ram_addr` at the very first write of a load. A bad count comparison moves the `load_done` pulse away from the final write, which shows within one load. A lost or sticky-failing error flag shows in the cycle after the high byte, and on every later cycle until reset.

// File: rtl/desc_loader_pkg.sv
// Shared definitions for the descriptor loader.
package desc_loader_pkg;

    // Load phase: two length bytes, then payload streaming.
    typedef enum logic [1:0] {
        PH_LEN_LO = 2'd0,
        PH_LEN_HI = 2'd1,
        PH_STREAM = 2'd2
    } load_phase_t;

endpackage

// File: rtl/dl_len_fsm.sv
// Phase sequencer and length register.
// Takes accepted bytes. The first byte is the length low byte, the second is
// the length high byte, and the rest are payload until last_payload is seen.
// Assumes take is already qualified by the access-register address.
module dl_len_fsm
    import desc_loader_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 500,
    localparam int LEN_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic [DATA_W-1:0] data,
    input  logic              last_payload,
    output load_phase_t       phase,
    output logic [LEN_W-1:0]  len_q,
    output logic              start,
    output logic              zero_len,
    output logic              overlong
);

    logic [DATA_W-1:0] lo_q;
    logic [LEN_W-1:0]  len_next;
    logic              hi_take;

    // Assemble the candidate length from the stored low byte and the incoming high byte.
    always_comb begin
        len_next = {data, lo_q};
        hi_take  = take && (phase == PH_LEN_HI);
        start    = hi_take && (len_next != '0);
        zero_len = hi_take && (len_next == '0);
        overlong = hi_take && (len_next > LEN_W'(DEPTH));
    end

    // Advance the phase and capture the length bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_LEN_LO;
            lo_q  <= '0;
            len_q <= '0;
        end else if (take) begin
            unique case (phase)
                PH_LEN_LO: begin
                    lo_q  <= data;
                    phase <= PH_LEN_HI;
                end
                PH_LEN_HI: begin
                    len_q <= len_next;
                    phase <= (len_next == '0) ? PH_LEN_LO : PH_STREAM;
                end
                PH_STREAM: begin
                    if (last_payload) phase <= PH_LEN_LO;
                end
                default: phase <= PH_LEN_LO;
            endcase
        end
    end

endmodule

// File: rtl/dl_byte_ctr.sv
// Payload byte counter.
// Counts the payload bytes of the current load. It reports whether the byte
// now arriving is the last one, and whether its index still fits in memory.
// Assumes clear and advance are never high together.
module dl_byte_ctr #(
    parameter int LEN_W  = 16,
    parameter int DEPTH  = 500,
    parameter int ADDR_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              advance,
    input  logic [LEN_W-1:0]  len,
    output logic              last,
    output logic              in_range,
    output logic [ADDR_W-1:0] addr
);

    logic [LEN_W-1:0] cnt_q;
    logic [LEN_W:0]   cnt_inc;

    // Decode the last-byte and address-fit conditions from the current count.
    always_comb begin
        cnt_inc  = {1'b0, cnt_q} + 1'b1;
        last     = (cnt_inc == {1'b0, len});
        in_range = (cnt_q < LEN_W'(DEPTH));
        addr     = cnt_q[ADDR_W-1:0];
    end

    // Hold the running count of payload bytes.
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt_q <= '0;
        else if (clear)   cnt_q <= '0;
        else if (advance) cnt_q <= cnt_q + 1'b1;
    end

endmodule

// File: rtl/dl_wr_port.sv
// Registered descriptor RAM write port.
// Turns a write request into a one-cycle strobe, with the address and data
// registered alongside it. Address and data hold their values between writes.
module dl_wr_port #(
    parameter int ADDR_W = 9,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fire,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    output logic              we_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] data_q
);

    // Register the strobe, address and data of each accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_q   <= 1'b0;
            addr_q <= '0;
            data_q <= '0;
        end else begin
            we_q <= fire;
            if (fire) begin
                addr_q <= addr;
                data_q <= data;
            end
        end
    end

endmodule

// File: rtl/desc_loader.sv
// Descriptor memory loader (top).
// Filters completed register bytes down to those for the access register.
// It reads a little-endian length from the first two bytes, then streams the
// payload into the descriptor RAM until the length is reached.
// Assumes byte_vld is high for one cycle per completed register byte.
module desc_loader
    import desc_loader_pkg::*;
#(
    parameter int          DEPTH      = 500,
    parameter int          DATA_W     = 8,
    parameter int          REG_W      = 6,
    parameter logic [5:0]  ACCESS_REG = 6'h30,
    localparam int         ADDR_W     = $clog2(DEPTH),
    localparam int         LEN_W      = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_vld,
    input  logic [REG_W-1:0]  byte_reg,
    input  logic [DATA_W-1:0] byte_data,
    output logic              ram_we,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [DATA_W-1:0] ram_wdata,
    output logic              load_done,
    output logic              loading,
    output logic              len_err
);

    load_phase_t       phase;
    logic [LEN_W-1:0]  len_q;
    logic              take;
    logic              start;
    logic              zero_len;
    logic              overlong;
    logic              last;
    logic              in_range;
    logic              advance;
    logic              fire;
    logic [ADDR_W-1:0] wr_addr;
    logic              done_d;

    // Accept only bytes addressed to the descriptor-access register.
    always_comb begin
        take    = byte_vld && (byte_reg == REG_W'(ACCESS_REG));
        advance = take && (phase == PH_STREAM);
        fire    = advance && in_range;
        done_d  = zero_len || (advance && last);
        loading = (phase == PH_STREAM);
    end

    dl_len_fsm #(
        .DATA_W (DATA_W),
        .DEPTH  (DEPTH)
    ) u_len_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .take         (take),
        .data         (byte_data),
        .last_payload (last),
        .phase        (phase),
        .len_q        (len_q),
        .start        (start),
        .zero_len     (zero_len),
        .overlong     (overlong)
    );

    dl_byte_ctr #(
        .LEN_W  (LEN_W),
        .DEPTH  (DEPTH),
        .ADDR_W (ADDR_W)
    ) u_byte_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (start),
        .advance  (advance),
        .len      (len_q),
        .last     (last),
        .in_range (in_range),
        .addr     (wr_addr)
    );

    dl_wr_port #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_wr_port (
        .clk    (clk),
        .rst_n  (rst_n),
        .fire   (fire),
        .addr   (wr_addr),
        .data   (byte_data),
        .we_q   (ram_we),
        .addr_q (ram_addr),
        .data_q (ram_wdata)
    );

    // Register the completion pulse, aligned with the final write.
    always_ff @(posedge clk) begin
        if (!rst_n) load_done <= 1'b0;
        else        load_done <= done_d;
    end

    // Hold the overlong-length flag until reset.
    always_ff @(posedge clk) begin
        if (!rst_n)        len_err <= 1'b0;
        else if (overlong) len_err <= 1'b1;
    end

endmodule

// File: rtl/desc_loader_checker.sv
// Temporal checks on the descriptor loader ports.
module desc_loader_checker #(
    parameter int         DEPTH      = 500,
    parameter int         REG_W      = 6,
    parameter logic [5:0] ACCESS_REG = 6'h30,
    parameter int         ADDR_W     = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic              byte_vld,
    input logic [REG_W-1:0]  byte_reg,
    input logic              ram_we,
    input logic [ADDR_W-1:0] ram_addr,
    input logic              load_done,
    input logic              loading,
    input logic              len_err
);

    a_r1_quiet_after_reset: assert property (@(posedge clk)
        !rst_n |=> (!ram_we && !load_done && !loading && !len_err));

    a_r2_write_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> $past(byte_vld && (byte_reg == REG_W'(ACCESS_REG))));

    a_r4_addr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> (int'(ram_addr) < DEPTH));

    a_r4_addr_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_we && $past(ram_we)) |-> (ram_addr == $past(ram_addr) + 1'b1));

    a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        load_done |=> !load_done);

    a_r5_done_ends_loading: assert property (@(posedge clk) disable iff (!rst_n)
        load_done |-> !loading);

    a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        len_err |=> len_err);

endmodule

bind desc_loader desc_loader_checker #(
    .DEPTH      (DEPTH),
    .REG_W      (REG_W),
    .ACCESS_REG (ACCESS_REG),
    .ADDR_W     (ADDR_W)
) u_desc_loader_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .byte_vld  (byte_vld),
    .byte_reg  (byte_reg),
    .ram_we    (ram_we),
    .ram_addr  (ram_addr),
    .load_done (load_done),
    .loading   (loading),
    .len_err   (len_err)
);

// File: tb/desc_loader_bench.sv
module desc_loader_bench;

    localparam int         CLK_PERIOD = 10;
    localparam int         MEM_BYTES  = 500;
    localparam logic [5:0] ACC        = 6'h30;
    localparam int         ROWS       = 14;

    // Row: vld, reg, data | we, addr, wdata, done, loading, err | requirement index
    localparam logic [39:0] VEC [ROWS] = '{
        {1'b1, ACC,   8'h03, 1'b0, 9'd0, 8'h00, 1'b0, 1'b0, 1'b0, 4'd3},
        {1'b1, 6'h31, 8'h55, 1'b0, 9'd0, 8'h00, 1'b0, 1'b0, 1'b0, 4'd2},
        {1'b1, ACC,   8'h00, 1'b0, 9'd0, 8'h00, 1'b0, 1'b1, 1'b0, 4'd3},
        {1'b0, ACC,   8'h99, 1'b0, 9'd0, 8'h00, 1'b0, 1'b1, 1'b0, 4'd9},
        {1'b1, ACC,   8'hA1, 1'b1, 9'd0, 8'hA1, 1'b0, 1'b1, 1'b0, 4'd4},
        {1'b1, 6'h12, 8'h77, 1'b0, 9'd0, 8'h00, 1'b0, 1'b1, 1'b0, 4'd2},
        {1'b1, ACC,   8'hB2, 1'b1, 9'd1, 8'hB2, 1'b0, 1'b1, 1'b0, 4'd4},
        {1'b1, ACC,   8'hC3, 1'b1, 9'd2, 8'hC3, 1'b1, 1'b0, 1'b0, 4'd5},
        {1'b1, ACC,   8'h00, 1'b0, 9'd0, 8'h00, 1'b0, 1'b0, 1'b0, 4'd5},
        {1'b1, ACC,   8'h00, 1'b0, 9'd0, 8'h00, 1'b1, 1'b0, 1'b0, 4'd6},
        {1'b1, ACC,   8'h02, 1'b0, 9'd0, 8'h00, 1'b0, 1'b0, 1'b0, 4'd3},
        {1'b1, ACC,   8'h00, 1'b0, 9'd0, 8'h00, 1'b0, 1'b1, 1'b0, 4'd3},
        {1'b1, ACC,   8'h5A, 1'b1, 9'd0, 8'h5A, 1'b0, 1'b1, 1'b0, 4'd4},
        {1'b1, ACC,   8'h6B, 1'b1, 9'd1, 8'h6B, 1'b1, 1'b0, 1'b0, 4'd5}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       byte_vld = 1'b0;
    logic [5:0] byte_reg = '0;
    logic [7:0] byte_data = '0;
    logic       ram_we;
    logic [8:0] ram_addr;
    logic [7:0] ram_wdata;
    logic       load_done;
    logic       loading;
    logic       len_err;
    int         errors = 0;
    int         checks = 0;
    int         cycles = 0;

    desc_loader u_desc_loader (
        .clk       (clk),
        .rst_n     (rst_n),
        .byte_vld  (byte_vld),
        .byte_reg  (byte_reg),
        .byte_data (byte_data),
        .ram_we    (ram_we),
        .ram_addr  (ram_addr),
        .ram_wdata (ram_wdata),
        .load_done (load_done),
        .loading   (loading),
        .len_err   (len_err)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    function automatic string req_name(input logic [3:0] idx);
        case (idx)
            4'd1:    return "R1";
            4'd2:    return "R2";
            4'd3:    return "R3";
            4'd4:    return "R4";
            4'd5:    return "R5";
            4'd6:    return "R6";
            4'd7:    return "R7";
            4'd8:    return "R8";
            default: return "R9";
        endcase
    endfunction

    function automatic logic [20:0] exp_vec(input logic we, input logic [8:0] a,
                                            input logic [7:0] d, input logic dn,
                                            input logic ld, input logic er);
        return {we, we ? a : 9'd0, we ? d : 8'd0, dn, ld, er};
    endfunction

    function automatic logic [20:0] observed();
        return {ram_we, ram_we ? ram_addr : 9'd0, ram_we ? ram_wdata : 8'd0,
                load_done, loading, len_err};
    endfunction

    task automatic check(input string req, input logic [20:0] exp);
        logic [20:0] act;
        act = observed();
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one cycle from a falling edge; return at the next falling edge.
    task automatic drive(input logic v, input logic [5:0] r, input logic [7:0] d);
        byte_vld  = v;
        byte_reg  = r;
        byte_data = d;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        @(negedge clk);
        drive(1'b0, ACC, 8'h00);
        drive(1'b0, ACC, 8'h00);
        check("R1", exp_vec(0, 0, 0, 0, 0, 0));
        rst_n = 1'b1;

        // Vector table walk
        for (int i = 0; i < ROWS; i++) begin
            drive(VEC[i][39], VEC[i][38:33], VEC[i][32:25]);
            check(req_name(VEC[i][3:0]),
                  exp_vec(VEC[i][24], VEC[i][23:15], VEC[i][14:7],
                          VEC[i][6], VEC[i][5], VEC[i][4]));
        end

        // R7: overlong length 502 (0x01F6)
        drive(1'b1, ACC, 8'hF6);
        check("R3", exp_vec(0, 0, 0, 0, 0, 0));
        drive(1'b1, ACC, 8'h01);
        check("R7", exp_vec(0, 0, 0, 0, 1, 1));
        for (int i = 0; i < 502; i++) begin
            drive(1'b1, ACC, 8'(i) ^ 8'h3C);
            check(i >= MEM_BYTES ? "R7" : (i == 501 ? "R5" : "R4"),
                  exp_vec(i < MEM_BYTES, 9'(i), 8'(i) ^ 8'h3C, i == 501, i != 501, 1));
        end
        // R7: error stays set through a following valid load of one byte
        drive(1'b1, ACC, 8'h01);
        drive(1'b1, ACC, 8'h00);
        drive(1'b1, ACC, 8'hAA);
        check("R7", exp_vec(1, 0, 8'hAA, 1, 0, 1));

        // R8: reset clears the error flag
        rst_n = 1'b0;
        drive(1'b0, ACC, 8'h00);
        rst_n = 1'b1;
        check("R8", exp_vec(0, 0, 0, 0, 0, 0));

        // R7 boundary: length exactly 500 (0x01F4) sets no error
        drive(1'b1, ACC, 8'hF4);
        drive(1'b1, ACC, 8'h01);
        check("R7", exp_vec(0, 0, 0, 0, 1, 0));
        for (int i = 0; i < MEM_BYTES; i++) begin
            if (i % 7 == 3) drive(1'b0, ACC, 8'hFF);
            drive(1'b1, ACC, 8'(i * 3));
            check(i == MEM_BYTES - 1 ? "R5" : "R9",
                  exp_vec(1, 9'(i), 8'(i * 3), i == MEM_BYTES - 1, i != MEM_BYTES - 1, 0));
        end

        // R8: reset in the middle of a load
        drive(1'b1, ACC, 8'h05);
        drive(1'b1, ACC, 8'h00);
        drive(1'b1, ACC, 8'h11);
        check("R4", exp_vec(1, 0, 8'h11, 0, 1, 0));
        rst_n = 1'b0;
        drive(1'b1, ACC, 8'h22);
        rst_n = 1'b1;
        check("R8", exp_vec(0, 0, 0, 0, 0, 0));
        drive(1'b1, ACC, 8'h01);
        check("R8", exp_vec(0, 0, 0, 0, 0, 0));
        drive(1'b1, ACC, 8'h00);
        check("R8", exp_vec(0, 0, 0, 0, 1, 0));
        drive(1'b1, ACC, 8'hEE);
        check("R8", exp_vec(1, 0, 8'hEE, 1, 0, 0));

        // R2: a foreign-register byte between length bytes changes nothing
        drive(1'b1, ACC, 8'h01);
        drive(1'b1, 6'h2F, 8'h07);
        check("R2", exp_vec(0, 0, 0, 0, 0, 0));
        drive(1'b1, ACC, 8'h00);
        drive(1'b1, ACC, 8'h4D);
        check("R2", exp_vec(1, 0, 8'h4D, 1, 0, 0));

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule